// File: doc/BRIEF.md
# Flash Range Signature Engine

The engine computes a 24-bit LFSR signature over a span of a flash array. When a signature command arrives while it is idle, it fixes the span from the supplied start address. It then reads the array one word per cycle through a synchronous read port with one cycle of latency and folds each 16-bit word into the LFSR. When the last word has been absorbed, it loads the result into its signature register and raises a one-cycle completion pulse.

Two range variants are chosen by a parameter. The large-block variant signs from the start page up to the end of the block and leaves out the final page. The small-block variant signs from the start page through the last word of the block. When its start address is above a threshold, it instead signs a fixed alternate region, for example a boot or factory-data area.

Top module: `flash_sig_engine`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `rd_en_o` are 0 and `sig_o` is 24'hFFFFFF.
- R2: Only a command code of 8'h0B with `cmd_valid_i` high starts signing. Any other code leaves `busy_o` at 0, produces no read and leaves `sig_o` unchanged.
- R3: The start address is rounded down to a multiple of 2**PAGE_W words. The first read is at that address, and each following cycle reads the next higher address, with no gaps.
- R4: In the large variant (BLOCK_KIND=0), the last word read is 2**ADDR_W - 2**PAGE_W - 1, so the final page of the block is never read.
- R5: The LFSR is seeded with 24'hFFFFFF when signing starts. Each word is shifted in most significant bit first. Each bit step computes fb = s[23] ^ bit, then s = {s[22:0],0}, then s is XORed with 24'h800063 when fb is 1. `sig_o` holds the final state.
- R6: For N words, `busy_o` is high for exactly N+1 cycles after the accepting edge. `done_o` is high for exactly the one cycle in which `busy_o` first returns to 0. `sig_o` takes its new value in that same cycle and stays constant while `busy_o` is high.
- R7: A signature command that arrives while `busy_o` is high is ignored. The range that is running is not changed.
- R8: In the small variant (BLOCK_KIND=1), a start address strictly above ALT_THRESH signs ALT_FIRST through ALT_LAST. Any other start address signs from the aligned start through 2**ADDR_W - 1.
- R9: In the large variant, a start address inside the final page produces no reads and no busy cycles. `done_o` pulses in the cycle after the command, and `sig_o` becomes 24'hFFFFFF.
- R10: Read data is taken from `rd_data_i` one cycle after the cycle in which `rd_en_o` is high for that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_i | input | 8 | Command code |
| start_addr_i | input | ADDR_W | Start word address |
| rd_en_o | output | 1 | Array read enable |
| rd_addr_o | output | ADDR_W | Array word address |
| rd_data_i | input | 16 | Array read data, valid one cycle after `rd_en_o` |
| busy_o | output | 1 | Signing in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sig_o | output | 24 | Signature register |

## Verification
The hardest situations to reach from the ports are a second command landing in the middle of a run, and a start address that falls inside the excluded final page. The bench drives the mid-run command after a fixed count of busy cycles, using a different start address. It then checks that the read span, the busy length and the signature all match the first command. For the empty case, it supplies an address inside the last page and expects a completion pulse with no reads. A second instance in the small variant is driven with start addresses just at and just above the threshold.

// File: rtl/sig_pkg.sv
package sig_pkg;
  localparam int unsigned SIG_W  = 24;
  localparam int unsigned DATA_W = 16;
  localparam logic [SIG_W-1:0] SIG_POLY = 24'h800063;
  localparam logic [SIG_W-1:0] SIG_SEED = 24'hFFFFFF;
  localparam logic [7:0] CMD_SIGN = 8'h0B;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN} sig_state_e;

  function automatic logic [SIG_W-1:0] lfsr_word(logic [SIG_W-1:0] s, logic [DATA_W-1:0] d);
    logic [SIG_W-1:0] t;
    logic fb;
    t = s;
    for (int b = DATA_W - 1; b >= 0; b--) begin
      fb = t[SIG_W-1] ^ d[b];
      t  = {t[SIG_W-2:0], 1'b0} ^ (fb ? SIG_POLY : '0);
    end
    return t;
  endfunction
endpackage

// File: rtl/sig_range.sv
module sig_range #(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned PAGE_W     = 6,
  parameter int unsigned BLOCK_KIND = 0,
  parameter int unsigned ALT_THRESH = 12'hF00,
  parameter int unsigned ALT_FIRST  = 12'h040,
  parameter int unsigned ALT_LAST   = 12'h07F
) (
  input  logic [ADDR_W-1:0] start_i,
  output logic [ADDR_W-1:0] first_o,
  output logic [ADDR_W-1:0] last_o,
  output logic              empty_o
);
  localparam int unsigned WORDS      = 1 << ADDR_W;
  localparam int unsigned PAGE_WORDS = 1 << PAGE_W;

  logic [ADDR_W-1:0] aligned;
  assign aligned = {start_i[ADDR_W-1:PAGE_W], {PAGE_W{1'b0}}};

  if (BLOCK_KIND == 0) begin : g_large
    localparam logic [ADDR_W-1:0] LAST_L = ADDR_W'(WORDS - PAGE_WORDS - 1);
    assign first_o = aligned;
    assign last_o  = LAST_L;
    assign empty_o = aligned > LAST_L;
  end else begin : g_small
    logic alt;
    assign alt     = start_i > ADDR_W'(ALT_THRESH);
    assign first_o = alt ? ADDR_W'(ALT_FIRST) : aligned;
    assign last_o  = alt ? ADDR_W'(ALT_LAST) : {ADDR_W{1'b1}};
    assign empty_o = 1'b0;
  end
endmodule

// File: rtl/sig_lfsr.sv
module sig_lfsr
  import sig_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              seed_i,
  input  logic              absorb_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [SIG_W-1:0]  next_o
);
  logic [SIG_W-1:0] s_q;

  assign next_o = lfsr_word(s_q, data_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       s_q <= SIG_SEED;
    else if (seed_i)   s_q <= SIG_SEED;
    else if (absorb_i) s_q <= next_o;
  end
endmodule

// File: rtl/sig_seq.sv
module sig_seq
  import sig_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [ADDR_W-1:0] first_i,
  input  logic [ADDR_W-1:0] last_i,
  input  logic              empty_i,
  output logic              seed_o,
  output logic              absorb_o,
  output logic              cap_o,
  output logic              empty_fin_o,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              busy_o,
  output logic              done_o
);
  sig_state_e        state_q;
  logic [ADDR_W-1:0] addr_q, last_q;
  logic              vld_q, lst_q, done_q, accept;

  assign accept      = (state_q == ST_IDLE) && go_i;
  assign seed_o      = accept;
  assign rd_en_o     = (state_q == ST_RUN);
  assign rd_addr_o   = addr_q;
  assign absorb_o    = vld_q;
  assign cap_o       = vld_q && lst_q;
  assign empty_fin_o = accept && empty_i;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      last_q  <= '0;
      vld_q   <= 1'b0;
      lst_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      vld_q  <= rd_en_o;
      lst_q  <= rd_en_o && (addr_q == last_q);
      done_q <= cap_o || empty_fin_o;
      case (state_q)
        ST_IDLE: if (accept && !empty_i) begin
          state_q <= ST_RUN;
          addr_q  <= first_i;
          last_q  <= last_i;
        end
        ST_RUN: begin
          addr_q <= addr_q + 1'b1;
          if (addr_q == last_q) state_q <= ST_DRAIN;
        end
        ST_DRAIN: if (cap_o) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R3
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_o && $past(rd_en_o)) |-> (rd_addr_o == $past(rd_addr_o) + 1'b1));
  // R4
  addr_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |-> (rd_addr_o <= last_q));
  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R6
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R10
  absorb_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    absorb_o |-> $past(rd_en_o));
endmodule

// File: rtl/flash_sig_engine.sv
module flash_sig_engine
  import sig_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned PAGE_W     = 6,
  parameter int unsigned BLOCK_KIND = 0,
  parameter int unsigned ALT_THRESH = 12'hF00,
  parameter int unsigned ALT_FIRST  = 12'h040,
  parameter int unsigned ALT_LAST   = 12'h07F
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [7:0]        cmd_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [15:0]       rd_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [23:0]       sig_o
);
  logic [ADDR_W-1:0] first, last;
  logic              empty, seed, absorb, cap, empty_fin, go;
  logic [SIG_W-1:0]  nxt, sig_q;

  assign go = cmd_valid_i && (cmd_i == CMD_SIGN);

  sig_range #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BLOCK_KIND(BLOCK_KIND),
    .ALT_THRESH(ALT_THRESH), .ALT_FIRST(ALT_FIRST), .ALT_LAST(ALT_LAST)
  ) u_range (
    .start_i(start_addr_i), .first_o(first), .last_o(last), .empty_o(empty)
  );

  sig_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .go_i(go),
    .first_i(first), .last_i(last), .empty_i(empty),
    .seed_o(seed), .absorb_o(absorb), .cap_o(cap), .empty_fin_o(empty_fin),
    .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o), .busy_o(busy_o), .done_o(done_o)
  );

  sig_lfsr u_lfsr (
    .clk_i(clk_i), .rst_ni(rst_ni), .seed_i(seed), .absorb_i(absorb),
    .data_i(rd_data_i), .next_o(nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sig_q <= SIG_SEED;
    else if (cap)       sig_q <= nxt;
    else if (empty_fin) sig_q <= SIG_SEED;
  end

  assign sig_o = sig_q;

  // R6
  sig_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> $stable(sig_o));
  // R3
  first_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (BLOCK_KIND == 0 && $rose(rd_en_o)) |-> (rd_addr_o[PAGE_W-1:0] == '0));
endmodule

// File: tb/sim_flash_sig_engine.sv
`timescale 1ns/1ps
module sim_flash_sig_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [7:0]  cmd = 8'h00;
  logic [7:0]  start = 8'h00;
  logic        cv [2];
  logic        rd_en [2];
  logic [7:0]  rd_addr [2];
  logic [15:0] rdata [2];
  logic        busy [2];
  logic        done [2];
  logic [23:0] sig [2];
  int          nrd [2];
  logic [7:0]  frst [2];
  logic [7:0]  lst [2];
  logic        clr = 1'b0;
  int          n_chk = 0, n_err = 0;

  flash_sig_engine #(.ADDR_W(8), .PAGE_W(4), .BLOCK_KIND(0)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cv[0]), .cmd_i(cmd), .start_addr_i(start),
    .rd_en_o(rd_en[0]), .rd_addr_o(rd_addr[0]), .rd_data_i(rdata[0]),
    .busy_o(busy[0]), .done_o(done[0]), .sig_o(sig[0]));

  flash_sig_engine #(.ADDR_W(8), .PAGE_W(4), .BLOCK_KIND(1),
    .ALT_THRESH(8'hC0), .ALT_FIRST(8'h10), .ALT_LAST(8'h2F)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cv[1]), .cmd_i(cmd), .start_addr_i(start),
    .rd_en_o(rd_en[1]), .rd_addr_o(rd_addr[1]), .rd_data_i(rdata[1]),
    .busy_o(busy[1]), .done_o(done[1]), .sig_o(sig[1]));

  function automatic logic [15:0] memf(logic [7:0] a);
    return (16'(a) * 16'h9E37) ^ 16'h5A5A;
  endfunction

  always @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (rd_en[i]) begin
        rdata[i] <= memf(rd_addr[i]);
        if (nrd[i] == 0) frst[i] <= rd_addr[i];
        lst[i] <= rd_addr[i];
        nrd[i] <= nrd[i] + 1;
      end
      if (clr) nrd[i] <= 0;
    end
  end

  function automatic logic [23:0] ref_sig(int f, int l);
    logic [23:0] s = 24'hFFFFFF;
    logic [15:0] d;
    logic fb;
    for (int a = f; a <= l; a++) begin
      d = memf(8'(a));
      for (int b = 15; b >= 0; b--) begin
        fb = s[23] ^ d[b];
        s = {s[22:0], 1'b0};
        if (fb) s = s ^ 24'h800063;
      end
    end
    return s;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_busy(int i, output int cnt);
    cnt = 0;
    while (busy[i] && cnt < 1000) begin
      cnt++;
      @(negedge clk);
    end
  endtask

  task automatic sign_run(int i, logic [7:0] st, int ef, int el, bit emp, string tag);
    int cnt, n;
    n = emp ? 0 : el - ef + 1;
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    cmd = 8'h0B; start = st; cv[i] = 1'b1;
    @(negedge clk);
    cv[i] = 1'b0;
    wait_busy(i, cnt);
    chk({tag, " R6 busy cycles"}, cnt, emp ? 0 : n + 1);
    chk({tag, " R6 done pulse"}, done[i], 1);
    chk({tag, " R3 read count"}, nrd[i], n);
    if (!emp) begin
      chk({tag, " R3 first addr"}, frst[i], ef);
      chk({tag, " R4 last addr"}, lst[i], el);
      chk({tag, " R5 signature"}, sig[i], ref_sig(ef, el));
    end else begin
      chk({tag, " R9 seed sig"}, sig[i], 24'hFFFFFF);
    end
    @(negedge clk);
    chk({tag, " R6 done clears"}, done[i], 0);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 2; i++) begin
      chk("R1 busy", busy[i], 0);
      chk("R1 done", done[i], 0);
      chk("R1 rd_en", rd_en[i], 0);
      chk("R1 sig", sig[i], 24'hFFFFFF);
    end
  endtask

  task automatic t_ignore(logic [7:0] code);
    logic [23:0] prev = sig[0];
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    cmd = code; start = 8'h00; cv[0] = 1'b1;
    @(negedge clk);
    cv[0] = 1'b0;
    chk("R2 busy", busy[0], 0);
    @(negedge clk);
    chk("R2 reads", nrd[0], 0);
    chk("R2 sig", sig[0], prev);
    chk("R2 done", done[0], 0);
  endtask

  task automatic t_busy_cmd;
    int cnt;
    logic [23:0] prev;
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    prev = sig[0];
    cmd = 8'h0B; start = 8'h50; cv[0] = 1'b1;
    @(negedge clk);
    cv[0] = 1'b0;
    repeat (5) @(negedge clk);
    chk("R6 sig held mid-run", sig[0], prev);
    start = 8'h00; cv[0] = 1'b1;
    @(negedge clk);
    cv[0] = 1'b0;
    wait_busy(0, cnt);
    chk("R7 busy cycles", cnt + 6, 161);
    chk("R7 first addr", frst[0], 8'h50);
    chk("R7 read count", nrd[0], 160);
    chk("R7 signature", sig[0], ref_sig(8'h50, 239));
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    cv[0] = 1'b0; cv[1] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ignore(8'h07);
    t_ignore(8'h0C);
    sign_run(0, 8'h00, 0, 239, 0, "full");
    sign_run(0, 8'h37, 8'h30, 239, 0, "mid");
    sign_run(0, 8'hE5, 8'hE0, 239, 0, "tail");
    sign_run(0, 8'hF3, 0, 0, 1, "R9 empty");
    t_busy_cmd();
    sign_run(1, 8'h45, 8'h40, 255, 0, "R8 small");
    sign_run(1, 8'hC0, 8'hC0, 255, 0, "R8 at thresh");
    sign_run(1, 8'hC1, 8'h10, 8'h2F, 0, "R8 alt");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule